// File: doc/BRIEF.md
# CAN interrupt flag unit

This block collects the event sources of a CAN controller and turns them into four interrupt request lines: wake-up, error, receive and transmit. The rest of the controller feeds it the empty status of three transmit buffers, a strobe for each received frame, the receive FIFO occupancy, an overrun strobe, the transmit and receive error counters, the internal sleep state and a bus activity indication. Software reaches it through a small write port. One write address holds the enable bits. The other address is a write-one-to-clear mask for the sticky flags.

The receive flag is driven by a three-state machine. `RX_EMPTY` means no message sits in the foreground slot. `RX_HELD` means a message is in the foreground and the flag is set. `RX_SHIFT` is a one-cycle gap while the next queued message moves into the foreground. The transitions are:

- `RX_EMPTY` to `RX_HELD` on a frame strobe.
- `RX_HELD` to `RX_SHIFT` on a release while two or more messages are stored.
- `RX_HELD` to `RX_EMPTY` on a release while fewer than two are stored.
- `RX_SHIFT` to `RX_HELD` unconditionally.
- `RX_HELD` stays in `RX_HELD` when a release and a frame strobe arrive together.

The error line does not follow a raw event. It follows changes of a bus-state range that is derived from each error counter. The wake-up source is live only while the controller is in internal sleep.

Top module: `can_irq_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every flag, enable, interrupt line and range field reads zero.
- R2: `txe` equals `tx_empty` at all times. `irq_tx` is high one cycle after any buffer is both empty and enabled. The transmit enables are bits 6:4 of an enable write (`wr_sel`=1), and bit 4 belongs to buffer 0.
- R3: With no message held, a `rx_frame` pulse sets the receive flag (`flags[0]`) at the next clock edge.
- R4: Clearing the receive flag while `rx_level` is 2 or more drops the flag for exactly one cycle, after which it is set again. Clearing it while `rx_level` is below 2 leaves it clear.
- R5: The wake flag (`flags[3]`) is set only by `bus_activity` while `sleep_mode` is high. Bus activity outside sleep leaves it clear.
- R6: `tx_state` encodes the transmit counter as follows: 00 for 0 to 95, 01 for 96 to 127, 10 for 128 to 255, and 11 above 255.
- R7: `rx_state` encodes the receive counter as follows: 00 for 0 to 95, 01 for 96 to 127, and 10 for 128 and above. It never shows 11.
- R8: The status-change flag (`flags[2]`) is set in the same cycle that `tx_state` or `rx_state` takes a new value, whether the counters are rising or falling.
- R9: A `rx_overrun` pulse sets the overrun flag (`flags[1]`) at the next edge.
- R10: A write with `wr_sel`=0 clears each flag whose data bit is 1. The bit order is 0 receive, 1 overrun, 2 status change, 3 wake. A set event in the same cycle as its clear keeps the flag set.
- R11: A write with `wr_sel`=1 loads the enables: bit 0 receive, 1 overrun, 2 status change, 3 wake. `irq_rx`, `irq_err` and `irq_wake` are registered copies of (flag AND enable). Each rises one cycle after its flag sets and falls one cycle after the flag clears or its enable is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_empty | input | 3 | Empty (not scheduled) status of each transmit buffer |
| rx_frame | input | 1 | Pulse: a frame was received successfully |
| rx_level | input | 3 | Receive FIFO occupancy, including the foreground slot |
| rx_overrun | input | 1 | Pulse: receive FIFO overrun |
| tx_err_cnt | input | 9 | Transmit error counter |
| rx_err_cnt | input | 8 | Receive error counter |
| sleep_mode | input | 1 | Controller is in internal sleep |
| bus_activity | input | 1 | Activity seen on the bus |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the flag clear mask, 1 selects the enable register |
| wr_data | input | 7 | Write data |
| flags | output | 4 | Sticky flags: wake, status change, overrun, receive (bit 3 down to bit 0) |
| txe | output | 3 | Transmit empty flags |
| tx_state | output | 2 | Transmit counter range |
| rx_state | output | 2 | Receive counter range |
| irq_wake | output | 1 | Wake-up interrupt request |
| irq_err | output | 1 | Error interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
The bench queues three received messages and releases them one at a time. A design that failed to re-arm would lose the queued messages, and one that never dropped the flag would hide the hand-over. The error counters sweep through every range boundary, including 95/96, 127/128 and 255/256, in both directions. A design with off-by-one thresholds, or one that flagged only rising changes, would miss a status change or show a wrong field. Clears that coincide with set events catch a design in which the clear wins. Wake-up attempts outside sleep and masked enables catch requests that should never appear, and the one-cycle request latency is sampled on both edges.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    typedef enum logic [1:0] {
        RNG_OK   = 2'b00,
        RNG_WARN = 2'b01,
        RNG_ERR  = 2'b10,
        RNG_OFF  = 2'b11
    } bus_range_t;

    localparam logic [31:0] WARN_LIMIT = 32'd96;
    localparam logic [31:0] ERR_LIMIT  = 32'd128;
    localparam logic [31:0] OFF_LIMIT  = 32'd256;

    localparam int NUM_FLAGS  = 4;
    localparam int BIT_RX     = 0;
    localparam int BIT_OVR    = 1;
    localparam int BIT_CSC    = 2;
    localparam int BIT_WAKE   = 3;
    localparam int EN_TX_LSB  = 4;

    typedef enum logic [1:0] {
        RX_EMPTY = 2'b00,
        RX_HELD  = 2'b01,
        RX_SHIFT = 2'b10
    } rx_state_t;

endpackage

// File: rtl/can_err_range.sv
module can_err_range
    import can_irq_pkg::*;
#(
    parameter int CW         = 9,
    parameter bit HAS_BUSOFF = 1'b1
) (
    input  logic [CW-1:0] cnt,
    output bus_range_t    range
);
    logic [31:0] wide;
    logic        off_hit;

    assign wide = 32'(cnt);

    generate
        if (HAS_BUSOFF) begin : g_busoff
            assign off_hit = (wide >= OFF_LIMIT);
        end else begin : g_no_busoff
            assign off_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        if (off_hit)
            range = RNG_OFF;
        else if (wide >= ERR_LIMIT)
            range = RNG_ERR;
        else if (wide >= WARN_LIMIT)
            range = RNG_WARN;
        else
            range = RNG_OK;
    end
endmodule

// File: rtl/can_rx_arm.sv
module can_rx_arm
    import can_irq_pkg::*;
#(
    parameter int LVLW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_in,
    input  logic            release_req,
    input  logic [LVLW-1:0] level,
    output logic            rx_flag
);
    localparam logic [LVLW-1:0] TWO = LVLW'(2);

    rx_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (frame_in) state_d = RX_HELD;
            RX_HELD:  if (release_req && !frame_in)
                          state_d = (level >= TWO) ? RX_SHIFT : RX_EMPTY;
            RX_SHIFT: state_d = RX_HELD;
            default:  state_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        rx_flag = (state_q == RX_HELD);
    end

    AST_RX_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && release_req && !frame_in && level >= TWO) |-> ##2 rx_flag); // R4
    AST_RX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && release_req && !frame_in && level < TWO) |=> !rx_flag); // R4
    AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && release_req && frame_in) |=> rx_flag); // R10
    AST_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_EMPTY && frame_in) |=> rx_flag); // R3
endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
    import can_irq_pkg::*;
#(
    parameter int TX_BUFS  = 3,
    parameter int TX_CW    = 9,
    parameter int RX_CW    = 8,
    parameter int RX_DEPTH = 4,
    localparam int LVLW    = $clog2(RX_DEPTH + 1),
    localparam int DW      = EN_TX_LSB + TX_BUFS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TX_BUFS-1:0] tx_empty,
    input  logic               rx_frame,
    input  logic [LVLW-1:0]    rx_level,
    input  logic               rx_overrun,
    input  logic [TX_CW-1:0]   tx_err_cnt,
    input  logic [RX_CW-1:0]   rx_err_cnt,
    input  logic               sleep_mode,
    input  logic               bus_activity,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [DW-1:0]      wr_data,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [TX_BUFS-1:0] txe,
    output logic [1:0]         tx_state,
    output logic [1:0]         rx_state,
    output logic               irq_wake,
    output logic               irq_err,
    output logic               irq_rx,
    output logic               irq_tx
);
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] ie_q;
    logic [TX_BUFS-1:0]   txie_q;
    logic                 rx_flag;
    logic [3:1]           sticky_q;
    logic [3:1]           set_vec;
    bus_range_t           tx_rng_now, rx_rng_now;
    bus_range_t           tx_rng_q, rx_rng_q;
    logic                 csc_evt;
    logic                 irq_wake_q, irq_err_q, irq_rx_q, irq_tx_q;

    assign clr_vec = wr_data[NUM_FLAGS-1:0] & {NUM_FLAGS{wr_en && !wr_sel}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= '0;
            txie_q <= '0;
        end else if (wr_en && wr_sel) begin
            ie_q   <= wr_data[NUM_FLAGS-1:0];
            txie_q <= wr_data[EN_TX_LSB +: TX_BUFS];
        end
    end

    can_err_range #(.CW(TX_CW), .HAS_BUSOFF(1'b1)) u_tx_rng (
        .cnt   (tx_err_cnt),
        .range (tx_rng_now)
    );

    can_err_range #(.CW(RX_CW), .HAS_BUSOFF(1'b0)) u_rx_rng (
        .cnt   (rx_err_cnt),
        .range (rx_rng_now)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_rng_q <= RNG_OK;
            rx_rng_q <= RNG_OK;
        end else begin
            tx_rng_q <= tx_rng_now;
            rx_rng_q <= rx_rng_now;
        end
    end

    assign csc_evt = (tx_rng_now != tx_rng_q) || (rx_rng_now != rx_rng_q);

    can_rx_arm #(.LVLW(LVLW)) u_rx_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_in    (rx_frame),
        .release_req (clr_vec[BIT_RX]),
        .level       (rx_level),
        .rx_flag     (rx_flag)
    );

    assign set_vec = {sleep_mode && bus_activity, csc_evt, rx_overrun};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= set_vec | (sticky_q & ~clr_vec[3:1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_wake_q <= 1'b0;
            irq_err_q  <= 1'b0;
            irq_rx_q   <= 1'b0;
            irq_tx_q   <= 1'b0;
        end else begin
            irq_rx_q   <= rx_flag & ie_q[BIT_RX];
            irq_err_q  <= (sticky_q[BIT_OVR] & ie_q[BIT_OVR]) |
                          (sticky_q[BIT_CSC] & ie_q[BIT_CSC]);
            irq_wake_q <= sticky_q[BIT_WAKE] & ie_q[BIT_WAKE];
            irq_tx_q   <= |(tx_empty & txie_q);
        end
    end

    assign flags    = {sticky_q, rx_flag};
    assign txe      = tx_empty;
    assign tx_state = tx_rng_q;
    assign rx_state = rx_rng_q;
    assign irq_wake = irq_wake_q;
    assign irq_err  = irq_err_q;
    assign irq_rx   = irq_rx_q;
    assign irq_tx   = irq_tx_q;

    AST_WAKE_ONLY_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[BIT_WAKE]) |-> $past(sleep_mode && bus_activity)); // R5
    AST_CSC_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tx_state) || !$stable(rx_state)) |-> flags[BIT_CSC]); // R8
    AST_RX_NO_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
        rx_state != 2'b11); // R7
    AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[BIT_OVR] && !rx_overrun) |=> !flags[BIT_OVR]); // R10
    AST_ERR_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> $past(flags[BIT_OVR] || flags[BIT_CSC])); // R11
    AST_TX_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> $past(|tx_empty)); // R2
endmodule

// File: tb/can_irq_unit_test.sv
module can_irq_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] tx_empty = '0;
    logic       rx_frame = 1'b0;
    logic [2:0] rx_level = '0;
    logic       rx_overrun = 1'b0;
    logic [8:0] tx_err_cnt = '0;
    logic [7:0] rx_err_cnt = '0;
    logic       sleep_mode = 1'b0;
    logic       bus_activity = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [6:0] wr_data = '0;
    logic [3:0] flags;
    logic [2:0] txe;
    logic [1:0] tx_state, rx_state;
    logic       irq_wake, irq_err, irq_rx, irq_tx;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    can_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .rx_frame(rx_frame),
        .rx_level(rx_level), .rx_overrun(rx_overrun), .tx_err_cnt(tx_err_cnt),
        .rx_err_cnt(rx_err_cnt), .sleep_mode(sleep_mode), .bus_activity(bus_activity),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .flags(flags), .txe(txe),
        .tx_state(tx_state), .rx_state(rx_state), .irq_wake(irq_wake),
        .irq_err(irq_err), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    // {tx count, rx count, expected tx range, expected rx range}
    localparam int NVEC = 15;
    localparam logic [20:0] VEC [0:NVEC-1] = '{
        {9'd95,  8'd0,   2'b00, 2'b00},
        {9'd96,  8'd0,   2'b01, 2'b00},
        {9'd127, 8'd95,  2'b01, 2'b00},
        {9'd128, 8'd96,  2'b10, 2'b01},
        {9'd255, 8'd127, 2'b10, 2'b01},
        {9'd256, 8'd128, 2'b11, 2'b10},
        {9'd300, 8'd255, 2'b11, 2'b10},
        {9'd255, 8'd255, 2'b10, 2'b10},
        {9'd128, 8'd128, 2'b10, 2'b10},
        {9'd127, 8'd127, 2'b01, 2'b01},
        {9'd96,  8'd96,  2'b01, 2'b01},
        {9'd95,  8'd95,  2'b00, 2'b00},
        {9'd0,   8'd0,   2'b00, 2'b00},
        {9'd0,   8'd200, 2'b00, 2'b10},
        {9'd0,   8'd0,   2'b00, 2'b00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [6:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_frame(input logic [2:0] lvl_after);
        rx_frame = 1'b1;
        tick();
        rx_frame = 1'b0;
        rx_level = lvl_after;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] prev_tx, prev_rx;
        @(negedge clk);
        tick();
        // R1 during reset
        chk("R1 flags", 32'(flags), 0);
        chk("R1 irqs", 32'({irq_wake, irq_err, irq_rx, irq_tx}), 0);
        chk("R1 ranges", 32'({tx_state, rx_state}), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 flags after", 32'(flags), 0);
        chk("R1 irqs after", 32'({irq_wake, irq_err, irq_rx, irq_tx}), 0);

        // Range sweep table: R6 R7 R8 R10
        prev_tx = 2'b00; prev_rx = 2'b00;
        for (int i = 0; i < NVEC; i++) begin
            logic changed;
            tx_err_cnt = VEC[i][20:12];
            rx_err_cnt = VEC[i][11:4];
            tick();
            changed = (VEC[i][3:2] != prev_tx) || (VEC[i][1:0] != prev_rx);
            chk($sformatf("R6 tx range vec %0d", i), 32'(tx_state), 32'(VEC[i][3:2]));
            chk($sformatf("R7 rx range vec %0d", i), 32'(rx_state), 32'(VEC[i][1:0]));
            chk($sformatf("R8 csc vec %0d", i), 32'(flags[2]), 32'(changed));
            if (changed) begin
                wr(1'b0, 7'h04);
                chk($sformatf("R10 csc clear vec %0d", i), 32'(flags[2]), 0);
            end
            prev_tx = VEC[i][3:2];
            prev_rx = VEC[i][1:0];
        end

        // Enable all
        wr(1'b1, 7'h7F);

        // R9 / R11 overrun and error line latency
        rx_overrun = 1'b1; tick(); rx_overrun = 1'b0;
        chk("R9 ovr set", 32'(flags[1]), 1);
        chk("R11 irq_err latency", 32'(irq_err), 0);
        tick();
        chk("R11 irq_err rise", 32'(irq_err), 1);
        wr(1'b0, 7'h02);
        chk("R10 ovr clear", 32'(flags[1]), 0);
        chk("R11 irq_err hold one", 32'(irq_err), 1);
        tick();
        chk("R11 irq_err fall", 32'(irq_err), 0);

        // R10 set wins over clear
        rx_overrun = 1'b1; wr(1'b0, 7'h02); rx_overrun = 1'b0;
        chk("R10 ovr set wins", 32'(flags[1]), 1);
        wr(1'b0, 7'h02);

        // R11 masked overrun enable
        wr(1'b1, 7'h7D);
        rx_overrun = 1'b1; tick(); rx_overrun = 1'b0;
        tick();
        chk("R11 masked irq_err", 32'(irq_err), 0);
        chk("R9 masked flag still set", 32'(flags[1]), 1);
        wr(1'b0, 7'h02);

        // R5 wake
        bus_activity = 1'b1; tick(); bus_activity = 1'b0;
        chk("R5 no wake outside sleep", 32'(flags[3]), 0);
        sleep_mode = 1'b1; tick();
        chk("R5 no wake without activity", 32'(flags[3]), 0);
        bus_activity = 1'b1; tick(); bus_activity = 1'b0;
        chk("R5 wake in sleep", 32'(flags[3]), 1);
        tick();
        chk("R11 irq_wake", 32'(irq_wake), 1);
        wr(1'b0, 7'h08);
        chk("R10 wake clear", 32'(flags[3]), 0);
        sleep_mode = 1'b0;

        // R3 / R4 three queued messages
        wr(1'b1, 7'h7F);
        pulse_frame(3'd1);
        chk("R3 rx first", 32'(flags[0]), 1);
        pulse_frame(3'd2);
        pulse_frame(3'd3);
        chk("R11 irq_rx", 32'(irq_rx), 1);
        wr(1'b0, 7'h01); rx_level = 3'd2;
        chk("R4 gap 1", 32'(flags[0]), 0);
        tick();
        chk("R4 rearm 1", 32'(flags[0]), 1);
        wr(1'b0, 7'h01); rx_level = 3'd1;
        chk("R4 gap 2", 32'(flags[0]), 0);
        tick();
        chk("R4 rearm 2", 32'(flags[0]), 1);
        wr(1'b0, 7'h01); rx_level = 3'd0;
        chk("R4 last released", 32'(flags[0]), 0);
        tick();
        chk("R4 stays clear", 32'(flags[0]), 0);
        chk("R11 irq_rx fall", 32'(irq_rx), 0);

        // R10 receive set wins
        pulse_frame(3'd1);
        rx_frame = 1'b1; wr(1'b0, 7'h01); rx_frame = 1'b0; rx_level = 3'd1;
        chk("R10 rx set wins", 32'(flags[0]), 1);
        wr(1'b0, 7'h01); rx_level = 3'd0;
        chk("R4 rx drained", 32'(flags[0]), 0);

        // R2 transmit
        tx_empty = 3'b101;
        tick();
        chk("R2 txe mirror", 32'(txe), 32'h5);
        chk("R2 irq_tx rise", 32'(irq_tx), 1);
        wr(1'b1, 7'h2F);
        chk("R2 irq_tx hold one", 32'(irq_tx), 1);
        tick();
        chk("R2 irq_tx masked", 32'(irq_tx), 0);
        tx_empty = 3'b010;
        tick();
        chk("R2 txe mirror 2", 32'(txe), 32'h2);
        chk("R2 irq_tx enabled buffer", 32'(irq_tx), 1);
        tx_empty = 3'b000;
        tick();
        chk("R2 irq_tx none empty", 32'(irq_tx), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule